// File: doc/BRIEF.md
# Translation Request Front-End Controller

This block sits in front of an address translation buffer and settles the fate of each memory request before any domain or permission logic sees it. It accepts one request at a time, holding a virtual address, an access kind (instruction fetch, data read or data write), a handful of request flags and the relevant control-register bits. It then takes one of three paths. It can answer at once with a physical address, it can query the translation buffer, or it can start a table walk through a start/ready handshake with an external walker and retry the buffer query once the walk is done.

Every request ends in exactly one registered response carrying a fault code, a physical address, an uncacheable attribute, a shareable attribute and the effective privilege. A monitor-clear request short-cuts everything. Misaligned data accesses fault without touching the buffer. With translation off, the address maps flat and cacheability follows the remap settings of region zero. A prefetch that misses in the buffer aborts instead of walking.

Top module: `tfe_front`

## Requirements
- R1: A request with `req_mon_clr_i` set completes with fault 0, physical address 0 and uncacheable 1. It issues no lookup and takes precedence over the alignment and translation rules.
- R2: Outside R1, the uncacheable output is 1 when a fetch (kind 2'b00) meets `ctl_icache_en_i`=0, or when a read (2'b01) or write (2'b10) meets `ctl_dcache_en_i`=0.
- R3: A read or write raises fault 4'h1 when both of these hold: `ctl_strict_align_i` is 1 or `req_allow_unal_i` is 0, and the low ALIGN_W bits of the cleaned address ANDed with `req_align_mask_i` are nonzero. Such a request issues no lookup. A fetch never takes this fault.
- R4: With `ctl_mmu_en_i`=0, the response carries fault 0, shareable 1 and a physical address equal to the cleaned virtual address, and no lookup is issued.
- R5: With translation off, uncacheable is also 1 in any of these cases: remap is disabled; the region-zero inner attribute is 0; the region-zero outer attribute is 0; the region-zero type is not 2'd2.
- R6: With translation on, one lookup of the cleaned address is issued. On a hit, the response carries `lkp_paddr_i`, fault 0 and shareable 0.
- R7: A prefetch that misses in the buffer completes with fault 4'h2 and never raises `walk_valid_o`.
- R8: A non-prefetch miss raises `walk_valid_o` and holds it until `walk_ready_i`. After a fault-free `walk_done_i`, exactly one more lookup is issued and its hit result is returned.
- R9: A nonzero `walk_fault_i` at `walk_done_i` is returned unchanged as the response fault code, with physical address 0.
- R10: `rsp_priv_o` is 1 exactly when `cpu_user_i` is 0 and `req_force_user_i` is 0.
- R11: The low MODE_W address bits are forced to 0 before any use: the alignment test, the lookup address and the flat physical address.
- R12: After reset `req_ready_o` is 1. It is 0 from acceptance until the response. `rsp_valid_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_vaddr_i | input | VA_W | Virtual address |
| req_kind_i | input | 2 | 00 fetch, 01 read, 10 write |
| req_mon_clr_i | input | 1 | Exclusive-monitor clear request |
| req_prefetch_i | input | 1 | Prefetch, no walk on miss |
| req_allow_unal_i | input | 1 | Request tolerates misalignment |
| req_force_user_i | input | 1 | Treat access as unprivileged |
| req_align_mask_i | input | ALIGN_W | Address bits that must be zero |
| cpu_user_i | input | 1 | Processor in user mode |
| ctl_mmu_en_i | input | 1 | Translation enable |
| ctl_strict_align_i | input | 1 | Strict alignment checking |
| ctl_icache_en_i | input | 1 | Instruction cache enable |
| ctl_dcache_en_i | input | 1 | Data cache enable |
| ctl_remap_en_i | input | 1 | Region remap enable |
| rgn0_inner_i | input | 2 | Region-zero inner attribute |
| rgn0_outer_i | input | 2 | Region-zero outer attribute |
| rgn0_type_i | input | 2 | Region-zero memory type |
| lkp_req_o | output | 1 | Buffer lookup pulse |
| lkp_vaddr_o | output | VA_W | Lookup address |
| lkp_done_i | input | 1 | Lookup result valid |
| lkp_hit_i | input | 1 | Lookup hit |
| lkp_paddr_i | input | VA_W | Physical address on hit |
| walk_valid_o | output | 1 | Walk start request |
| walk_ready_i | input | 1 | Walker takes the request |
| walk_vaddr_o | output | VA_W | Address to walk |
| walk_done_i | input | 1 | Walk finished |
| walk_fault_i | input | FLT_W | Walk fault code, 0 when clean |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | FLT_W | Fault code |
| rsp_paddr_o | output | VA_W | Physical address |
| rsp_uncache_o | output | 1 | Uncacheable |
| rsp_shareable_o | output | 1 | Shareable |
| rsp_priv_o | output | 1 | Effective privilege |

## Verification
The bench goes after the precedence corners. The first is a monitor clear carrying a misaligned address with strict checking on; a design that ordered its checks wrongly would report an alignment fault or issue a lookup. The second is a misaligned fetch, which must still translate. The third is an address whose only set bit is a mode bit; if the bits were cleaned late, a spurious alignment fault would appear. Further tests cover each region-zero attribute that forces uncacheable under flat mapping, where a decode missing one term would report a cacheable access. They also cover a prefetch miss, which a careless walk path would send to the walker, and a clean walk followed by the retry lookup, whose count and returned address expose a skipped or doubled retry. A walker that holds off ready shows whether the start request is dropped early.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    DEC_MONCLR,
    DEC_ALIGN,
    DEC_FLAT,
    DEC_LOOKUP
  } dec_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_LKWAIT,
    S_WALK,
    S_WWAIT,
    S_RELK
  } st_e;

  localparam logic [3:0] FLT_NONE    = 4'h0;
  localparam logic [3:0] FLT_ALIGN   = 4'h1;
  localparam logic [3:0] FLT_PF_MISS = 4'h2;
  localparam logic [1:0] RGN_TYPE_OK = 2'd2;

  typedef struct packed {
    logic monclr;
    logic allow_unal;
    logic force_user;
    logic user;
  } flags_t;

  typedef struct packed {
    logic       mmu;
    logic       strict;
    logic       ic;
    logic       dc;
    logic       remap;
    logic [1:0] inner;
    logic [1:0] outer;
    logic [1:0] rtype;
  } ctl_t;

endpackage

// File: rtl/tfe_capture.sv
module tfe_capture
  import tfe_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int ALIGN_W = 3,
  parameter int MODE_W  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [1:0]         kind_i,
  input  logic               prefetch_i,
  input  logic [ALIGN_W-1:0] mask_i,
  input  flags_t             flags_i,
  input  ctl_t               ctl_i,
  output logic [VA_W-1:0]    va_o,
  output acc_e               kind_o,
  output logic               prefetch_o,
  output logic [ALIGN_W-1:0] mask_o,
  output flags_t             flags_o,
  output ctl_t               ctl_o
);

  logic [VA_W-1:0] va_clean;

  // mode bits cleared before the address is stored
  generate
    if (MODE_W > 0) begin : g_mode_clr
      assign va_clean = {vaddr_i[VA_W-1:MODE_W], {MODE_W{1'b0}}};
    end else begin : g_mode_keep
      assign va_clean = vaddr_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_o       <= '0;
      kind_o     <= ACC_FETCH;
      prefetch_o <= 1'b0;
      mask_o     <= '0;
      flags_o    <= '0;
      ctl_o      <= '0;
    end else if (take_i) begin
      va_o       <= va_clean;
      kind_o     <= acc_e'(kind_i);
      prefetch_o <= prefetch_i;
      mask_o     <= mask_i;
      flags_o    <= flags_i;
      ctl_o      <= ctl_i;
    end
  end

endmodule

// File: rtl/tfe_classify.sv
module tfe_classify
  import tfe_pkg::*;
#(
  parameter int ALIGN_W = 3
) (
  input  acc_e               kind_i,
  input  logic [ALIGN_W-1:0] va_lo_i,
  input  logic [ALIGN_W-1:0] mask_i,
  input  flags_t             flags_i,
  input  ctl_t               ctl_i,
  output dec_e               dec_o,
  output logic               unc_en_o,
  output logic               unc_flat_o,
  output logic               priv_o
);

  logic is_fetch;
  logic chk_align;
  logic misaligned;

  assign is_fetch   = (kind_i == ACC_FETCH);
  assign chk_align  = !is_fetch && (ctl_i.strict || !flags_i.allow_unal);
  assign misaligned = |(va_lo_i & mask_i);

  assign unc_en_o   = is_fetch ? !ctl_i.ic : !ctl_i.dc;
  assign unc_flat_o = !ctl_i.remap || (ctl_i.inner == 2'd0) ||
                      (ctl_i.outer == 2'd0) || (ctl_i.rtype != RGN_TYPE_OK);
  assign priv_o     = !flags_i.user && !flags_i.force_user;

  // precedence: monitor clear, alignment, flat mapping, lookup
  always_comb begin
    if (flags_i.monclr)             dec_o = DEC_MONCLR;
    else if (chk_align && misaligned) dec_o = DEC_ALIGN;
    else if (!ctl_i.mmu)            dec_o = DEC_FLAT;
    else                            dec_o = DEC_LOOKUP;
  end

endmodule

// File: rtl/tfe_seq.sv
module tfe_seq
  import tfe_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             ready_o,
  input  dec_e             dec_i,
  input  logic             unc_en_i,
  input  logic             unc_flat_i,
  input  logic             priv_i,
  input  logic             prefetch_i,
  input  logic [VA_W-1:0]  va_i,
  output logic             lkp_req_o,
  input  logic             lkp_done_i,
  input  logic             lkp_hit_i,
  input  logic [VA_W-1:0]  lkp_paddr_i,
  output logic             walk_valid_o,
  input  logic             walk_ready_i,
  input  logic             walk_done_i,
  input  logic [FLT_W-1:0] walk_fault_i,
  output logic             rsp_valid_o,
  output logic [FLT_W-1:0] rsp_fault_o,
  output logic [VA_W-1:0]  rsp_paddr_o,
  output logic             rsp_uncache_o,
  output logic             rsp_shareable_o,
  output logic             rsp_priv_o
);

  st_e              st_q, st_d;
  logic             fin;
  logic [FLT_W-1:0] fin_flt;
  logic [VA_W-1:0]  fin_pa;
  logic             fin_unc;
  logic             fin_shr;

  always_comb begin
    st_d         = st_q;
    fin          = 1'b0;
    fin_flt      = FLT_W'(FLT_NONE);
    fin_pa       = '0;
    fin_unc      = unc_en_i;
    fin_shr      = 1'b0;
    ready_o      = (st_q == S_IDLE);
    walk_valid_o = (st_q == S_WALK);
    lkp_req_o    = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid_i) st_d = S_DECIDE;
      S_DECIDE: begin
        unique case (dec_i)
          DEC_MONCLR: begin
            fin     = 1'b1;
            fin_unc = 1'b1;
          end
          DEC_ALIGN: begin
            fin     = 1'b1;
            fin_flt = FLT_W'(FLT_ALIGN);
          end
          DEC_FLAT: begin
            fin     = 1'b1;
            fin_pa  = va_i;
            fin_unc = unc_en_i || unc_flat_i;
            fin_shr = 1'b1;
          end
          default: begin
            lkp_req_o = 1'b1;
            st_d      = S_LKWAIT;
          end
        endcase
      end
      S_LKWAIT: begin
        if (lkp_done_i) begin
          if (lkp_hit_i) begin
            fin    = 1'b1;
            fin_pa = lkp_paddr_i;
          end else if (prefetch_i) begin
            fin     = 1'b1;
            fin_flt = FLT_W'(FLT_PF_MISS);
          end else begin
            st_d = S_WALK;
          end
        end
      end
      S_WALK: if (walk_ready_i) st_d = S_WWAIT;
      S_WWAIT: begin
        if (walk_done_i) begin
          if (walk_fault_i != '0) begin
            fin     = 1'b1;
            fin_flt = walk_fault_i;
          end else begin
            st_d = S_RELK;
          end
        end
      end
      S_RELK: begin
        lkp_req_o = 1'b1;
        st_d      = S_LKWAIT;
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= S_IDLE;
      rsp_valid_o     <= 1'b0;
      rsp_fault_o     <= '0;
      rsp_paddr_o     <= '0;
      rsp_uncache_o   <= 1'b0;
      rsp_shareable_o <= 1'b0;
      rsp_priv_o      <= 1'b0;
    end else begin
      st_q        <= st_d;
      rsp_valid_o <= fin;
      if (fin) begin
        rsp_fault_o     <= fin_flt;
        rsp_paddr_o     <= fin_pa;
        rsp_uncache_o   <= fin_unc;
        rsp_shareable_o <= fin_shr;
        rsp_priv_o      <= priv_i;
      end
    end
  end

endmodule

// File: rtl/tfe_front.sv
module tfe_front
  import tfe_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int ALIGN_W = 3,
  parameter int MODE_W  = 1,
  parameter int FLT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [1:0]         req_kind_i,
  input  logic               req_mon_clr_i,
  input  logic               req_prefetch_i,
  input  logic               req_allow_unal_i,
  input  logic               req_force_user_i,
  input  logic [ALIGN_W-1:0] req_align_mask_i,
  input  logic               cpu_user_i,
  input  logic               ctl_mmu_en_i,
  input  logic               ctl_strict_align_i,
  input  logic               ctl_icache_en_i,
  input  logic               ctl_dcache_en_i,
  input  logic               ctl_remap_en_i,
  input  logic [1:0]         rgn0_inner_i,
  input  logic [1:0]         rgn0_outer_i,
  input  logic [1:0]         rgn0_type_i,
  output logic               lkp_req_o,
  output logic [VA_W-1:0]    lkp_vaddr_o,
  input  logic               lkp_done_i,
  input  logic               lkp_hit_i,
  input  logic [VA_W-1:0]    lkp_paddr_i,
  output logic               walk_valid_o,
  input  logic               walk_ready_i,
  output logic [VA_W-1:0]    walk_vaddr_o,
  input  logic               walk_done_i,
  input  logic [FLT_W-1:0]   walk_fault_i,
  output logic               rsp_valid_o,
  output logic [FLT_W-1:0]   rsp_fault_o,
  output logic [VA_W-1:0]    rsp_paddr_o,
  output logic               rsp_uncache_o,
  output logic               rsp_shareable_o,
  output logic               rsp_priv_o
);

  flags_t             flags_in, cap_flags;
  ctl_t               ctl_in, cap_ctl;
  logic [VA_W-1:0]    cap_va;
  acc_e               cap_kind;
  logic               cap_pf;
  logic [ALIGN_W-1:0] cap_mask;
  dec_e               dec;
  logic               unc_en, unc_flat, priv;

  assign flags_in = '{monclr: req_mon_clr_i, allow_unal: req_allow_unal_i,
                      force_user: req_force_user_i, user: cpu_user_i};
  assign ctl_in   = '{mmu: ctl_mmu_en_i, strict: ctl_strict_align_i,
                      ic: ctl_icache_en_i, dc: ctl_dcache_en_i,
                      remap: ctl_remap_en_i, inner: rgn0_inner_i,
                      outer: rgn0_outer_i, rtype: rgn0_type_i};

  tfe_capture #(.VA_W(VA_W), .ALIGN_W(ALIGN_W), .MODE_W(MODE_W)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (req_valid_i && req_ready_o),
    .vaddr_i    (req_vaddr_i),
    .kind_i     (req_kind_i),
    .prefetch_i (req_prefetch_i),
    .mask_i     (req_align_mask_i),
    .flags_i    (flags_in),
    .ctl_i      (ctl_in),
    .va_o       (cap_va),
    .kind_o     (cap_kind),
    .prefetch_o (cap_pf),
    .mask_o     (cap_mask),
    .flags_o    (cap_flags),
    .ctl_o      (cap_ctl)
  );

  tfe_classify #(.ALIGN_W(ALIGN_W)) i_classify (
    .kind_i     (cap_kind),
    .va_lo_i    (cap_va[ALIGN_W-1:0]),
    .mask_i     (cap_mask),
    .flags_i    (cap_flags),
    .ctl_i      (cap_ctl),
    .dec_o      (dec),
    .unc_en_o   (unc_en),
    .unc_flat_o (unc_flat),
    .priv_o     (priv)
  );

  tfe_seq #(.VA_W(VA_W), .FLT_W(FLT_W)) i_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .ready_o         (req_ready_o),
    .dec_i           (dec),
    .unc_en_i        (unc_en),
    .unc_flat_i      (unc_flat),
    .priv_i          (priv),
    .prefetch_i      (cap_pf),
    .va_i            (cap_va),
    .lkp_req_o       (lkp_req_o),
    .lkp_done_i      (lkp_done_i),
    .lkp_hit_i       (lkp_hit_i),
    .lkp_paddr_i     (lkp_paddr_i),
    .walk_valid_o    (walk_valid_o),
    .walk_ready_i    (walk_ready_i),
    .walk_done_i     (walk_done_i),
    .walk_fault_i    (walk_fault_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_uncache_o   (rsp_uncache_o),
    .rsp_shareable_o (rsp_shareable_o),
    .rsp_priv_o      (rsp_priv_o)
  );

  assign lkp_vaddr_o  = cap_va;
  assign walk_vaddr_o = cap_va;

endmodule

// File: rtl/tfe_front_chk.sv
module tfe_front_chk #(
  parameter int VA_W   = 32,
  parameter int MODE_W = 1,
  parameter int FLT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic [1:0]       req_kind_i,
  input logic             req_mon_clr_i,
  input logic             req_prefetch_i,
  input logic             lkp_req_o,
  input logic [VA_W-1:0]  lkp_vaddr_o,
  input logic             walk_valid_o,
  input logic             walk_ready_i,
  input logic             rsp_valid_o,
  input logic [FLT_W-1:0] rsp_fault_o,
  input logic [VA_W-1:0]  rsp_paddr_o,
  input logic             rsp_uncache_o,
  input logic             rsp_shareable_o
);

  logic [VA_W-1:0] sh_va;
  logic            sh_fetch, sh_mc, sh_pf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_va    <= '0;
      sh_fetch <= 1'b0;
      sh_mc    <= 1'b0;
      sh_pf    <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      sh_va    <= (req_vaddr_i >> MODE_W) << MODE_W;
      sh_fetch <= (req_kind_i == 2'b00);
      sh_mc    <= req_mon_clr_i;
      sh_pf    <= req_prefetch_i;
    end
  end

  p_monclr_rsp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && sh_mc |-> rsp_paddr_o == '0 && rsp_uncache_o && rsp_fault_o == '0);

  p_monclr_nolkp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_o |-> !sh_mc);

  p_fetch_noalign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && sh_fetch |-> rsp_fault_o != FLT_W'(1));

  p_flat_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_shareable_o |-> rsp_paddr_o == sh_va && rsp_fault_o == '0);

  p_pf_nowalk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_valid_o |-> !sh_pf);

  p_walk_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_valid_o && !walk_ready_i |=> walk_valid_o);

  p_lkp_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_o |-> lkp_vaddr_o == sh_va);

  p_rsp_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lkp_req_o && !walk_valid_o);

endmodule

bind tfe_front tfe_front_chk #(.VA_W(VA_W), .MODE_W(MODE_W), .FLT_W(FLT_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_vaddr_i     (req_vaddr_i),
  .req_kind_i      (req_kind_i),
  .req_mon_clr_i   (req_mon_clr_i),
  .req_prefetch_i  (req_prefetch_i),
  .lkp_req_o       (lkp_req_o),
  .lkp_vaddr_o     (lkp_vaddr_o),
  .walk_valid_o    (walk_valid_o),
  .walk_ready_i    (walk_ready_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_uncache_o   (rsp_uncache_o),
  .rsp_shareable_o (rsp_shareable_o)
);

// File: tb/test_tfe_front.sv
module test_tfe_front;

  localparam logic [31:0] PA_OFS = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_mc = 1'b0, req_pf = 1'b0, req_alw = 1'b0, req_fu = 1'b0;
  logic [2:0]  req_mask = '0;
  logic        cpu_user = 1'b0;
  logic        mmu = 1'b0, strict = 1'b0, ic = 1'b0, dc = 1'b0, remap = 1'b0;
  logic [1:0]  inr = '0, outr = '0, typ = '0;
  logic        lkp_req;
  logic [31:0] lkp_vaddr;
  logic        lkp_done = 1'b0, lkp_hit = 1'b0;
  logic [31:0] lkp_paddr = '0;
  logic        walk_valid, walk_ready = 1'b0;
  logic [31:0] walk_vaddr;
  logic        walk_done = 1'b0;
  logic [3:0]  walk_fault = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_fault;
  logic [31:0] rsp_paddr;
  logic        rsp_unc, rsp_shr, rsp_priv;

  int checks = 0, errors = 0;
  int lk_cnt = 0, wk_cnt = 0, rdy_dly = 0;
  logic cur_hit = 1'b0, filled = 1'b0, hold_bad = 1'b0;
  logic [3:0] cur_wflt = '0;

  always #5 clk = ~clk;

  tfe_front i_tfe_front (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_kind_i(req_kind),
    .req_mon_clr_i(req_mc), .req_prefetch_i(req_pf),
    .req_allow_unal_i(req_alw), .req_force_user_i(req_fu),
    .req_align_mask_i(req_mask), .cpu_user_i(cpu_user),
    .ctl_mmu_en_i(mmu), .ctl_strict_align_i(strict),
    .ctl_icache_en_i(ic), .ctl_dcache_en_i(dc), .ctl_remap_en_i(remap),
    .rgn0_inner_i(inr), .rgn0_outer_i(outr), .rgn0_type_i(typ),
    .lkp_req_o(lkp_req), .lkp_vaddr_o(lkp_vaddr),
    .lkp_done_i(lkp_done), .lkp_hit_i(lkp_hit), .lkp_paddr_i(lkp_paddr),
    .walk_valid_o(walk_valid), .walk_ready_i(walk_ready), .walk_vaddr_o(walk_vaddr),
    .walk_done_i(walk_done), .walk_fault_i(walk_fault),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .rsp_uncache_o(rsp_unc), .rsp_shareable_o(rsp_shr), .rsp_priv_o(rsp_priv)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        mc, pf, alw, fu, usr;
    logic [2:0]  mask;
    logic [31:0] va;
    logic        mmu, st, ic, dc, rm;
    logic [1:0]  inr, outr, typ;
    logic        hit;
    logic [3:0]  wflt;
    logic [3:0]  eflt;
    logic [1:0]  esel;
    logic        eunc, eshr, epriv;
    logic [1:0]  elk, ewk;
  } vec_t;

  // esel: 0 zero, 1 cleaned va, 2 cleaned va + PA_OFS
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd1,'1,'0,'0,'0,'0,3'b110,32'h0000_1006,'1,'1,'1,'1,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd0,2'd0,'1,'0,'1,2'd0,2'd0},
    '{2'd0,'0,'0,'0,'0,'0,3'b110,32'h0000_1006,'1,'1,'0,'1,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd0,2'd2,'1,'0,'1,2'd1,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b000,32'h0000_2000,'1,'0,'1,'0,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd0,2'd2,'1,'0,'1,2'd1,2'd0},
    '{2'd2,'0,'0,'1,'0,'1,3'b000,32'h0000_2400,'1,'0,'0,'1,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd0,2'd2,'0,'0,'0,2'd1,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b010,32'h0000_2002,'1,'1,'1,'1,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd1,2'd0,'0,'0,'1,2'd0,2'd0},
    '{2'd2,'0,'0,'0,'0,'0,3'b100,32'h0000_2004,'1,'0,'1,'0,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd1,2'd0,'1,'0,'1,2'd0,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b110,32'h0000_2006,'1,'0,'1,'1,'0,2'd1,2'd1,2'd2,'1,4'd0, 4'd0,2'd2,'0,'0,'1,2'd1,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b000,32'h0000_5000,'0,'0,'1,'1,'0,2'd1,2'd1,2'd2,'0,4'd0, 4'd0,2'd1,'1,'1,'1,2'd0,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b000,32'h0000_5100,'0,'0,'1,'1,'1,2'd1,2'd1,2'd2,'0,4'd0, 4'd0,2'd1,'0,'1,'1,2'd0,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b000,32'h0000_5200,'0,'0,'1,'1,'1,2'd0,2'd1,2'd2,'0,4'd0, 4'd0,2'd1,'1,'1,'1,2'd0,2'd0},
    '{2'd2,'0,'0,'1,'0,'0,3'b000,32'h0000_5300,'0,'0,'1,'1,'1,2'd1,2'd1,2'd1,'0,4'd0, 4'd0,2'd1,'1,'1,'1,2'd0,2'd0},
    '{2'd1,'0,'1,'1,'0,'0,3'b000,32'h0000_6000,'1,'0,'1,'1,'0,2'd1,2'd1,2'd2,'0,4'd0, 4'd2,2'd0,'0,'0,'1,2'd1,2'd0},
    '{2'd1,'0,'0,'1,'0,'0,3'b000,32'h0000_7000,'1,'0,'1,'1,'0,2'd1,2'd1,2'd2,'0,4'd0, 4'd0,2'd2,'0,'0,'1,2'd2,2'd1},
    '{2'd2,'0,'0,'1,'0,'0,3'b000,32'h0000_7400,'1,'0,'1,'1,'0,2'd1,2'd1,2'd2,'0,4'd9, 4'd9,2'd0,'0,'0,'1,2'd1,2'd1},
    '{2'd0,'0,'0,'0,'1,'0,3'b000,32'h0000_8000,'0,'0,'1,'1,'1,2'd1,2'd0,2'd2,'0,4'd0, 4'd0,2'd1,'1,'1,'0,2'd0,2'd0},
    '{2'd1,'0,'0,'0,'0,'0,3'b001,32'h0000_3001,'0,'1,'1,'1,'1,2'd1,2'd1,2'd2,'0,4'd0, 4'd0,2'd1,'0,'1,'1,2'd0,2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run(input vec_t v, input int idx);
    logic [31:0] cva, epa;
    bit got;
    cva = {v.va[31:1], 1'b0};
    epa = (v.esel == 2'd0) ? 32'h0 : (v.esel == 2'd1) ? cva : cva + PA_OFS;
    lk_cnt = 0; wk_cnt = 0; filled = 1'b0; cur_hit = v.hit; cur_wflt = v.wflt;
    @(negedge clk);
    req_kind = v.kind; req_mc = v.mc; req_pf = v.pf; req_alw = v.alw; req_fu = v.fu;
    cpu_user = v.usr; req_mask = v.mask; req_vaddr = v.va;
    mmu = v.mmu; strict = v.st; ic = v.ic; dc = v.dc; remap = v.rm;
    inr = v.inr; outr = v.outr; typ = v.typ;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, $sformatf("R12 busy v%0d", idx), 64'(req_ready), 64'd0);
    got = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (rsp_valid) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, $sformatf("R12 response v%0d", idx), 64'(got), 64'd1);
    chk(rsp_fault == v.eflt, $sformatf("R1 R3 R7 R9 fault v%0d", idx), 64'(rsp_fault), 64'(v.eflt));
    chk(rsp_paddr == epa, $sformatf("R4 R6 R11 paddr v%0d", idx), 64'(rsp_paddr), 64'(epa));
    chk(rsp_unc == v.eunc, $sformatf("R2 R5 uncache v%0d", idx), 64'(rsp_unc), 64'(v.eunc));
    chk(rsp_shr == v.eshr, $sformatf("R4 shareable v%0d", idx), 64'(rsp_shr), 64'(v.eshr));
    chk(rsp_priv == v.epriv, $sformatf("R10 priv v%0d", idx), 64'(rsp_priv), 64'(v.epriv));
    chk(lk_cnt == int'(v.elk), $sformatf("R6 R8 lookups v%0d", idx), 64'(lk_cnt), 64'(v.elk));
    chk(wk_cnt == int'(v.ewk), $sformatf("R7 R8 walks v%0d", idx), 64'(wk_cnt), 64'(v.ewk));
    @(negedge clk);
    chk(rsp_valid == 1'b0, $sformatf("R12 pulse v%0d", idx), 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, $sformatf("R12 idle v%0d", idx), 64'(req_ready), 64'd1);
  endtask

  // buffer and walker models
  initial begin
    fork
      forever begin
        logic [31:0] va_l;
        @(negedge clk);
        if (lkp_req) begin
          lk_cnt++;
          va_l = lkp_vaddr;
          @(negedge clk);
          lkp_done = 1'b1;
          lkp_hit = cur_hit || filled;
          lkp_paddr = va_l + PA_OFS;
          @(negedge clk);
          lkp_done = 1'b0;
          lkp_hit = 1'b0;
        end
      end
      forever begin
        @(negedge clk);
        if (walk_valid) begin
          wk_cnt++;
          for (int d = 0; d < rdy_dly; d++) begin
            @(negedge clk);
            if (!walk_valid) hold_bad = 1'b1;
          end
          walk_ready = 1'b1;
          @(negedge clk);
          walk_ready = 1'b0;
          repeat (2) @(negedge clk);
          walk_done = 1'b1;
          walk_fault = cur_wflt;
          if (cur_wflt == 4'd0) filled = 1'b1;
          @(negedge clk);
          walk_done = 1'b0;
          walk_fault = '0;
        end
      end
    join_none
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12 reset ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R12 reset rsp", 64'(rsp_valid), 64'd0);
    chk(!lkp_req && !walk_valid, "R12 reset idle outputs", 64'({lkp_req, walk_valid}), 64'd0);

    for (int k = 0; k < NV; k++) run(VEC[k], k);

    // R8: walker holds off ready; start request must stay up
    rdy_dly = 5;
    hold_bad = 1'b0;
    run(VEC[12], 100);
    chk(hold_bad == 1'b0, "R8 walk start held", 64'(hold_bad), 64'd0);
    rdy_dly = 0;

    // R9: a different walk fault code passes through
    run('{2'd0,'0,'0,'0,'0,'0,3'b000,32'h0000_9000,'1,'0,'1,'1,'0,2'd1,2'd1,2'd2,'0,4'd14,
          4'd14,2'd0,'0,'0,'1,2'd1,2'd1}, 101);

    // R1 with translation off still returns zero and skips the flat mapping
    run('{2'd2,'1,'0,'0,'0,'1,3'b000,32'h0000_A000,'0,'0,'1,'1,'1,2'd1,2'd1,2'd2,'0,4'd0,
          4'd0,2'd0,'1,'0,'0,2'd0,2'd0}, 102);

    finish_sim();
  end

endmodule